// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned integer by another over several clock cycles. It produces one quotient bit per clock by long division. A one-cycle `start` pulse, given while the block is idle, captures the dividend and the divisor. The block then runs one iteration per clock for `WIDTH` clocks. When it finishes, it raises `done` for one cycle and presents the quotient and remainder. These results stay stable until the next accepted start.

Three registers hold the working state:
- The partial remainder is one bit wider than the operands, so the sign of each trial difference is visible.
- A second register starts out holding the dividend. It shifts those bits out at the top while quotient bits enter at the bottom.
- The third register holds the captured divisor.

Each iteration shifts the remainder and quotient registers left together and subtracts the divisor. When the difference is negative, the iteration adds the divisor back in the same clock. A zero divisor raises a flag, and the arithmetic itself then yields an all-ones quotient and a remainder equal to the dividend.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: When `start` is high at a clock edge while `busy` is 0, `busy` is 1 after that edge. The operands present at that edge are the ones used, and later changes to `dividend` and `divisor` have no effect on the result.
- R3: `done` first goes high after the WIDTH-th clock edge following the accepting edge. `busy` stays high after each of the edges in between and is 0 once `done` is high.
- R4: `done` is high for exactly one cycle per accepted start.
- R5: For a nonzero divisor, when `done` is high, `quotient` equals the integer quotient and `remainder` equals dividend modulo divisor. In particular, the remainder is less than the divisor.
- R6: With WIDTH=4, dividing 7 by 3 gives quotient 2 and remainder 1.
- R7: For a zero divisor, `div_by_zero` is 1 when `done` is high, `quotient` is all ones, and `remainder` equals the dividend.
- R8: A `start` pulse while `busy` is 1 is ignored. The running division completes with its original operands at its original time, and no second `done` follows.
- R9: While the block is idle and `start` is low, `quotient`, `remainder` and `div_by_zero` hold their values.
- R10: `div_by_zero` is cleared by the next accepted start whose divisor is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only when idle |
| dividend | input | WIDTH | Unsigned dividend, captured on an accepted start |
| divisor | input | WIDTH | Unsigned divisor, captured on an accepted start |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when results are ready |
| quotient | output | WIDTH | Quotient; valid from `done` until the next accepted start |
| remainder | output | WIDTH | Remainder; valid from `done` until the next accepted start |
| div_by_zero | output | 1 | Set when the captured divisor was zero |

## Verification
The hardest condition to reach from the ports is a start request that lands partway through a running division. The operand inputs must also carry different values at that moment, so that a wrongly accepted restart would be visible. The bench raises `start` with fresh operands a few cycles after an accepted start. It then checks the original result, the original completion cycle, and the absence of a second `done`.

An exhaustive sweep over all 4-bit operand pairs covers the cases where the restore happens in every bit position, as well as the zero divisor. Each sweep step also measures the latency.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;

  // One restoring-division iteration for an operand width of w bits.
  // part_in is w+1 bits wide, quo_in and dvs are w bits wide.
  // The result is packed as {negative_flag, next_partial, next_quotient}.
  function automatic logic [64:0] step_pack(input int unsigned w,
                                            input logic [32:0] part_in,
                                            input logic [31:0] quo_in,
                                            input logic [31:0] dvs);
    logic [32:0] shifted;
    logic [32:0] trial;
    logic [32:0] mask;
    logic [31:0] qmask;
    logic [31:0] next_q;
    logic        neg;
    mask    = (33'd1 << (w + 1)) - 33'd1;
    qmask   = 32'((33'd1 << w) - 33'd1);
    shifted = ((part_in << 1) | {32'd0, quo_in[w-1]}) & mask;
    trial   = (shifted - {1'b0, dvs}) & mask;
    neg     = trial[w];
    next_q  = (quo_in << 1) & qmask;
    if (neg) begin
      trial = (trial + {1'b0, dvs}) & mask;
    end else begin
      next_q = next_q | 32'd1;
    end
    step_pack = {neg, trial[31:0], next_q};
  endfunction

endpackage

// File: rtl/div_control.sv
module div_control #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic step_en,
  output logic last_step,
  output logic busy,
  output logic done
);
  import div_pkg::*;

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  div_state_e      state_q;
  logic [CW-1:0]   iter_q;
  logic            done_q;

  assign load_en   = start && (state_q == ST_IDLE);
  assign step_en   = (state_q == ST_RUN);
  assign last_step = step_en && (iter_q == LAST);
  assign busy      = step_en;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      if (load_en) begin
        state_q <= ST_RUN;
        iter_q  <= '0;
      end else if (last_step) begin
        state_q <= ST_IDLE;
        iter_q  <= '0;
      end else if (step_en) begin
        iter_q <= iter_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             step_en,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quo_val,
  output logic [WIDTH-1:0] rem_val,
  output logic [WIDTH-1:0] dvs_val,
  output logic             zero_dvs,
  output logic             trial_neg
);
  import div_pkg::*;

  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    part_q;
  logic [WIDTH-1:0] quo_q;
  logic [WIDTH-1:0] dvs_q;
  logic             zero_q;

  logic [64:0]      packed_step;
  logic [AW-1:0]    part_next;
  logic [WIDTH-1:0] quo_next;

  always_comb begin
    packed_step = step_pack(WIDTH, 33'(part_q), 32'(quo_q), 32'(dvs_q));
    trial_neg   = packed_step[64];
    part_next   = packed_step[32 +: AW];
    quo_next    = packed_step[0 +: WIDTH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      zero_q <= 1'b0;
    end else if (load_en) begin
      part_q <= '0;
      quo_q  <= dividend;
      dvs_q  <= divisor;
      zero_q <= (divisor == '0);
    end else if (step_en) begin
      part_q <= part_next;
      quo_q  <= quo_next;
    end
  end

  assign quo_val  = quo_q;
  assign rem_val  = part_q[WIDTH-1:0];
  assign dvs_val  = dvs_q;
  assign zero_dvs = zero_q;

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);

  logic             load_en;
  logic             step_en;
  logic             last_step;
  logic             trial_neg;
  logic [WIDTH-1:0] dvs_held;

  div_control #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_en   (load_en),
    .step_en   (step_en),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .step_en   (step_en),
    .dividend  (dividend),
    .divisor   (divisor),
    .quo_val   (quotient),
    .rem_val   (remainder),
    .dvs_val   (dvs_held),
    .zero_dvs  (div_by_zero),
    .trial_neg (trial_neg)
  );

endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             div_by_zero,
  input logic [WIDTH-1:0] dvs_held
);
  localparam int LW = $clog2(WIDTH + 1) + 1;

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (start && !busy) lat_q <= '0;
    else if (busy) lat_q <= lat_q + 1'b1;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LW'(WIDTH)) && !busy);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (remainder < dvs_held));

  // R7
  zero_quo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (quotient == {WIDTH{1'b1}}));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

endmodule

bind restoring_divider restoring_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_by_zero (div_by_zero),
  .dvs_held    (dvs_held)
);

// File: tb/restoring_divider_tb.sv
module restoring_divider_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  restoring_divider #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero)
  );

  always #5 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives start before an edge, releases it after; returns after the done cycle is sampled.
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit scramble, input bit poke_busy, output int lat);
    int k;
    lat = -1;
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after accept", busy, 1);
    if (scramble) begin dividend = ~a; divisor = b + 4'd5; end
    for (k = 1; k <= W + 3; k++) begin
      if (poke_busy && k == 2) begin
        dividend = a ^ 4'hA; divisor = b ^ 4'h3; start = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (done && lat < 0) lat = k;
      if (lat < 0 && k < W) chk("R3 busy while running", busy, 1);
      if (lat >= 0) break;
    end
  endtask

  task automatic expect_result(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    if (b == 0) begin
      chk({req, " R7 flag"}, div_by_zero, 1);
      chk({req, " R7 quotient"}, quotient, {W{1'b1}});
      chk({req, " R7 remainder"}, remainder, a);
    end else begin
      chk({req, " R5 quotient"}, quotient, a / b);
      chk({req, " R5 remainder"}, remainder, a % b);
      chk({req, " R10 flag clear"}, div_by_zero, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 dbz", div_by_zero, 0);
    chk("R1 quotient", quotient, 0);
    chk("R1 remainder", remainder, 0);
  endtask

  task automatic t_example();
    int lat;
    run_div(4'd7, 4'd3, 1'b0, 1'b0, lat);
    chk("R3 latency", lat, W);
    chk("R3 busy low at done", busy, 0);
    chk("R6 quotient", quotient, 2);
    chk("R6 remainder", remainder, 1);
    @(posedge clk); @(negedge clk);
    chk("R4 done drops", done, 0);
  endtask

  task automatic t_capture();
    int lat;
    run_div(4'd13, 4'd4, 1'b1, 1'b0, lat);
    chk("R2 latency", lat, W);
    expect_result("R2 captured operands", 4'd13, 4'd4);
  endtask

  task automatic t_exhaustive();
    int lat;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_div(W'(a), W'(b), 1'b0, 1'b0, lat);
        chk("R3 latency sweep", lat, W);
        expect_result("sweep", W'(a), W'(b));
      end
    end
  endtask

  task automatic t_ignore_busy();
    int lat;
    run_div(4'd14, 4'd5, 1'b0, 1'b1, lat);
    chk("R8 latency unchanged", lat, W);
    expect_result("R8 original operands", 4'd14, 4'd5);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 no second done", done, 0);
      chk("R8 no restart", busy, 0);
    end
  endtask

  task automatic t_hold();
    int lat;
    logic [W-1:0] q0, r0;
    run_div(4'd11, 4'd0, 1'b0, 1'b0, lat);
    expect_result("R7 zero divisor", 4'd11, 4'd0);
    q0 = quotient; r0 = remainder;
    dividend = 4'd1; divisor = 4'd1;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 quotient hold", quotient, q0);
      chk("R9 remainder hold", remainder, r0);
      chk("R9 flag hold", div_by_zero, 1);
    end
    run_div(4'd9, 4'd2, 1'b0, 1'b0, lat);
    chk("R10 flag cleared", div_by_zero, 0);
    expect_result("R10 after zero", 4'd9, 4'd2);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_example();
    t_capture();
    t_ignore_busy();
    t_hold();
    t_exhaustive();
    summary();
  end

endmodule